// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides, for each received CAN frame, whether the frame is kept. It also reports which filter matched. The identifier arrives as four bytes that the receiver has already assembled, together with a one-cycle valid strobe. Eight acceptance code bytes and eight mask bytes supply the filter settings. The block regroups these same byte pairs into one of four configurations, chosen by a mode input:

- two wide filters, one per bank;
- four half-width filters, two per bank;
- eight single-byte filters;
- a closed setting that rejects every frame.

Slots 0 to 3 form the first bank and slots 4 to 7 the second. Each filter compares the identifier against its code bits bit by bit, and the mask decides which bit positions are ignored. The result is registered. An accept pulse, a per-filter hit vector and the lowest matching filter number appear on the clock after the strobe. The receive path uses the accept pulse to decide whether to store the frame. Software can read the hit index to dispatch the frame without decoding the identifier again.

Top module: `can_acc_filter`

## Requirements
- R1: `filt_mode` selects the configuration: 0 gives two 32-bit filters, 1 gives four 16-bit filters, 2 gives eight 8-bit filters and 3 is closed. The mode is sampled in the same cycle as `id_valid`, so changing it between frames only affects the next frame.
- R2: Byte k of `acc_code`/`acc_mask` is bits [8k+7:8k], and identifier byte j (IDRj) of `id_bytes` is bits [8j+7:8j]. A mask bit of 1 makes that bit position don't care. A mask bit of 0 requires the identifier bit to equal the code bit.
- R3: In mode 0, hit bit 0 is set when IDR0..IDR3 match slots 0..3. Hit bit 1 is set when IDR0..IDR3 match slots 4..7. Hit bits 7:2 are 0.
- R4: In mode 1, hit bit 0 uses IDR0/IDR1 against slots 0/1, and hit bit 1 uses IDR0/IDR1 against slots 2/3. Hit bits 2 and 3 do the same with slots 4/5 and 6/7. IDR2 and IDR3 have no effect, and hit bits 7:4 are 0.
- R5: In mode 2, hit bit k is set when IDR0 matches slot k. IDR1 to IDR3 have no effect.
- R6: In mode 3, no frame is accepted and the hit vector is 0, whatever the codes and masks are.
- R7: `rx_accept` is a single-cycle pulse on the clock after `id_valid`, high exactly when some hit bit is set.
- R8: `hit_idx` is the lowest-numbered set hit bit, and 0 when there is no hit.
- R9: After synchronous reset all outputs are 0. `hit_vec` and `hit_idx` hold their values until the next `id_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| filt_mode | input | 2 | Filter configuration select |
| acc_code | input | 64 | Eight acceptance code bytes |
| acc_mask | input | 64 | Eight mask bytes (1 = ignore bit) |
| id_bytes | input | 32 | Assembled identifier bytes IDR0..IDR3 |
| id_valid | input | 1 | Identifier bytes valid for one cycle |
| rx_accept | output | 1 | Frame accepted pulse |
| hit_idx | output | 3 | Lowest matching filter number |
| hit_vec | output | 8 | Per-filter hit bits |

## Verification
A wrong byte pairing or a wrong bank split shows up on the first frame in the affected mode. The bench therefore sends frames that should match exactly one filter in each mode, and checks both the hit bit and the index one clock after the strobe. Frames that differ from a filter only in ignored or unused bytes catch a comparator that looks at the wrong operand. Overlapping hits expose a priority encoder that favours the wrong end. Idle cycles with changing inputs reveal outputs that fail to hold.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
  typedef enum logic [1:0] {
    FM_WIDE32 = 2'd0,
    FM_HALF16 = 2'd1,
    FM_BYTE8  = 2'd2,
    FM_CLOSED = 2'd3
  } filt_mode_e;
endpackage

// File: rtl/can_acc_cmp.sv
// Masked comparison of one data word against one code word.
module can_acc_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  input  logic [W-1:0] code,
  input  logic [W-1:0] mask,
  output logic         match
);
  assign match = (((data ^ code) & ~mask) == '0);
endmodule

// File: rtl/can_acc_hit_map.sv
// Combines per-slot byte matches into filter hits for the selected mode.
module can_acc_hit_map
  import can_acc_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ID_BYTES  = 4
) (
  input  filt_mode_e           mode,
  input  logic [NUM_SLOTS-1:0] m_id0,  // slot k against IDR0
  input  logic [NUM_SLOTS-1:0] m_id1,  // slot k against IDR1
  input  logic [NUM_SLOTS-1:0] m_pos,  // slot k against IDR(k mod ID_BYTES)
  output logic [NUM_SLOTS-1:0] hits
);
  localparam int NUM_BANKS = NUM_SLOTS / ID_BYTES;
  localparam int NUM_HALF  = NUM_SLOTS / 2;

  always_comb begin
    hits = '0;
    unique case (mode)
      FM_WIDE32: begin
        for (int b = 0; b < NUM_BANKS; b++)
          hits[b] = &m_pos[b*ID_BYTES +: ID_BYTES];
      end
      FM_HALF16: begin
        for (int f = 0; f < NUM_HALF; f++)
          hits[f] = m_id0[2*f] & m_id1[2*f+1];
      end
      FM_BYTE8:  hits = m_id0;
      default:   hits = '0;
    endcase
  end
endmodule

// File: rtl/can_acc_prio.sv
// Lowest-index-first encoder.
module can_acc_prio #(
  parameter int N     = 8,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IW'(i);
  end
endmodule

// File: rtl/can_acc_filter.sv
module can_acc_filter
  import can_acc_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_SLOTS = 8,
  parameter int ID_BYTES  = 4,
  localparam int IW       = $clog2(NUM_SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0]                  filt_mode,
  input  logic [NUM_SLOTS*BYTE_W-1:0] acc_code,
  input  logic [NUM_SLOTS*BYTE_W-1:0] acc_mask,
  input  logic [ID_BYTES*BYTE_W-1:0]  id_bytes,
  input  logic                        id_valid,
  output logic                        rx_accept,
  output logic [IW-1:0]               hit_idx,
  output logic [NUM_SLOTS-1:0]        hit_vec
);
  logic [NUM_SLOTS-1:0] m_id0, m_id1, m_pos, hits_c;
  logic [IW-1:0]        idx_c;
  filt_mode_e           mode;

  assign mode = filt_mode_e'(filt_mode);

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam int P = k % ID_BYTES;
    can_acc_cmp #(.W(BYTE_W)) u_c0 (
      .data (id_bytes[0 +: BYTE_W]),
      .code (acc_code[k*BYTE_W +: BYTE_W]),
      .mask (acc_mask[k*BYTE_W +: BYTE_W]),
      .match(m_id0[k])
    );
    can_acc_cmp #(.W(BYTE_W)) u_c1 (
      .data (id_bytes[BYTE_W +: BYTE_W]),
      .code (acc_code[k*BYTE_W +: BYTE_W]),
      .mask (acc_mask[k*BYTE_W +: BYTE_W]),
      .match(m_id1[k])
    );
    can_acc_cmp #(.W(BYTE_W)) u_cp (
      .data (id_bytes[P*BYTE_W +: BYTE_W]),
      .code (acc_code[k*BYTE_W +: BYTE_W]),
      .mask (acc_mask[k*BYTE_W +: BYTE_W]),
      .match(m_pos[k])
    );
  end

  can_acc_hit_map #(.NUM_SLOTS(NUM_SLOTS), .ID_BYTES(ID_BYTES)) u_map (
    .mode (mode),
    .m_id0(m_id0),
    .m_id1(m_id1),
    .m_pos(m_pos),
    .hits (hits_c)
  );

  can_acc_prio #(.N(NUM_SLOTS)) u_prio (
    .req(hits_c),
    .idx(idx_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_accept <= 1'b0;
      hit_idx   <= '0;
      hit_vec   <= '0;
    end else begin
      rx_accept <= id_valid & (|hits_c);
      if (id_valid) begin
        hit_vec <= hits_c;
        hit_idx <= idx_c;
      end
    end
  end
endmodule

// File: rtl/can_acc_filter_chk.sv
module can_acc_filter_chk
  import can_acc_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int IW       = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           filt_mode,
  input logic                 id_valid,
  input logic                 rx_accept,
  input logic [IW-1:0]        hit_idx,
  input logic [NUM_SLOTS-1:0] hit_vec
);
  logic                 v_q;
  logic [1:0]           mode_q;
  logic [NUM_SLOTS-1:0] below;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      mode_q <= 2'd0;
    end else begin
      v_q    <= id_valid;
      mode_q <= filt_mode;
    end
  end

  always_comb begin
    below = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      below[i] = (i < int'(hit_idx));
  end

  a_r7_accept_after_valid: assert property (@(posedge clk) disable iff (rst)
    rx_accept |-> v_q);
  a_r7_accept_is_or: assert property (@(posedge clk) disable iff (rst)
    v_q |-> (rx_accept == (|hit_vec)));
  a_r6_closed_silent: assert property (@(posedge clk) disable iff (rst)
    (v_q && mode_q == FM_CLOSED) |-> (hit_vec == '0 && !rx_accept));
  a_r3_two_hits_only: assert property (@(posedge clk) disable iff (rst)
    (v_q && mode_q == FM_WIDE32) |-> ((hit_vec >> 2) == '0));
  a_r4_four_hits_only: assert property (@(posedge clk) disable iff (rst)
    (v_q && mode_q == FM_HALF16) |-> ((hit_vec >> (NUM_SLOTS/2)) == '0));
  a_r8_lowest_hit: assert property (@(posedge clk) disable iff (rst)
    rx_accept |-> (hit_vec[hit_idx] && ((hit_vec & below) == '0)));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !v_q |-> ($stable(hit_vec) && $stable(hit_idx)));
endmodule

bind can_acc_filter can_acc_filter_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .filt_mode(filt_mode),
  .id_valid (id_valid),
  .rx_accept(rx_accept),
  .hit_idx  (hit_idx),
  .hit_vec  (hit_vec)
);

// File: tb/sim_can_acc_filter.sv
`timescale 1ns/1ps
module sim_can_acc_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  filt_mode = 2'd0;
  logic [63:0] acc_code = '0;
  logic [63:0] acc_mask = '0;
  logic [31:0] id_bytes = '0;
  logic        id_valid = 1'b0;
  logic        rx_accept;
  logic [2:0]  hit_idx;
  logic [7:0]  hit_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_acc_filter u0 (.*);

  task automatic chk(string req, logic [7:0] vec, logic [2:0] idx, logic acc);
    checks++;
    if (hit_vec !== vec || hit_idx !== idx || rx_accept !== acc) begin
      errors++;
      $display("FAIL %s: vec=%h idx=%0d acc=%b expected vec=%h idx=%0d acc=%b",
               req, hit_vec, hit_idx, rx_accept, vec, idx, acc);
    end
  endtask

  // id given as {IDR3,IDR2,IDR1,IDR0}; result sampled one clock after strobe
  task automatic send(logic [1:0] m, logic [31:0] id);
    @(negedge clk);
    filt_mode = m; id_bytes = id; id_valid = 1'b1;
    @(negedge clk);
    id_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 reset", 8'h00, 3'd0, 1'b0);
  endtask

  task automatic t_wide;
    // slots 0..7 = 11 22 33 44 55 66 77 88
    acc_code = 64'h8877665544332211; acc_mask = '0;
    send(2'd0, 32'h44332211); chk("R3 bank0", 8'h01, 3'd0, 1'b1);
    @(negedge clk);           chk("R7 pulse ends", 8'h01, 3'd0, 1'b0);
    send(2'd0, 32'h88776655); chk("R3 bank1", 8'h02, 3'd1, 1'b1);
    send(2'd0, 32'h45332211); chk("R2 bit mismatch", 8'h00, 3'd0, 1'b0);
    acc_mask = 64'h0000_0000_0100_0000;
    send(2'd0, 32'h45332211); chk("R2 masked bit", 8'h01, 3'd0, 1'b1);
    acc_mask = 64'hFFFF_FFFF_0000_0000;
    send(2'd0, 32'h44332211); chk("R8 both hit lowest", 8'h03, 3'd0, 1'b1);
    acc_mask = '0;
  endtask

  task automatic t_half;
    send(2'd1, 32'h00004433); chk("R4 filter1", 8'h02, 3'd1, 1'b1);
    send(2'd1, 32'h00008877); chk("R4 filter3", 8'h08, 3'd3, 1'b1);
    send(2'd1, 32'hFFFF2211); chk("R4 IDR2/3 ignored", 8'h01, 3'd0, 1'b1);
    send(2'd1, 32'h00006655); chk("R4 filter2", 8'h04, 3'd2, 1'b1);
  endtask

  task automatic t_byte;
    send(2'd2, 32'hABCDEF66); chk("R5 slot5", 8'h20, 3'd5, 1'b1);
    acc_mask = 64'h0000_0000_0000_00FF;
    send(2'd2, 32'h00000066); chk("R8 slot0 wins", 8'h21, 3'd0, 1'b1);
    acc_mask = '0;
    send(2'd2, 32'h00000099); chk("R5 no match", 8'h00, 3'd0, 1'b0);
  endtask

  task automatic t_closed;
    acc_mask = '1;
    send(2'd3, 32'h44332211); chk("R6 closed", 8'h00, 3'd0, 1'b0);
    acc_mask = '0;
  endtask

  task automatic t_hold_mode;
    send(2'd2, 32'h00000033); chk("R5 slot2", 8'h04, 3'd2, 1'b1);
    @(negedge clk); filt_mode = 2'd0; id_bytes = 32'h88776655;
    @(negedge clk); chk("R9 hold idle", 8'h04, 3'd2, 1'b0);
    @(negedge clk); chk("R1 mode change waits", 8'h04, 3'd2, 1'b0);
    send(2'd0, 32'h88776655); chk("R1 new mode used", 8'h02, 3'd1, 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_wide();
    t_half();
    t_byte();
    t_closed();
    t_hold_mode();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule